// File: doc/BRIEF.md
# Delayed-Readback SPI Isolation Bridge

This bridge sits between an SPI host and one downstream SPI device that lives on the far side of an isolation boundary. Towards the host it behaves as an SPI target; towards the device it rebuilds a fresh SPI bus. All primary inputs pass through two-flop synchronisers into the `clk` domain. Each bit the host shifts in is sent across an abstract one-bit forward message channel. The secondary state machine places that bit on the downstream data line and holds the downstream clock low for a programmed number of cycles. It then raises the clock, samples the device's reply bit and sends it back over a reverse message channel into a circular buffer on the primary side.

The host never waits for the round trip, because the reply it reads comes from a buffer whose read pointer trails the write pointer by exactly one word. Every word read therefore belongs to the previous transfer. The select may stay low across several words in a row (page mode), and the one-word lag still holds. An 8-bit configuration register sets the word length and a two-bit speed code. The host writes it over the same SPI pins while a separate configuration select is low. A load strobe from the host is turned into a fixed-width downstream pulse.

Top module: `iso_spi_bridge`

## Requirements
- R1: After the primary select goes low, the secondary select `s_ss_n` goes low and `p_miso_oe` is high. `p_miso` already carries the MSB of the word captured during the previous transfer, before the first rising edge of `p_sclk`.
- R2: Each rising edge of `p_sclk` while the select is low captures `p_mosi` and forwards it. The downstream device receives the host's bits MSB first, in the same order.
- R3: For each forwarded bit, the secondary side sets `s_mosi` and drives `s_sclk` low for exactly 1 + 2*(3 - speed) `clk` cycles. It then raises `s_sclk`, samples `s_miso` in that same cycle, and keeps `s_sclk` high until the next bit arrives.
- R4: With speed code 0 or 1, `p_miso` moves to the next buffered bit after a falling edge of `p_sclk`, and it is unchanged while `p_sclk` is high.
- R5: With speed code 2 or 3, `p_miso` moves to the next buffered bit after a rising edge of `p_sclk`.
- R6: After the primary select goes high and any bit in flight completes, `p_miso_oe` is 0, `s_ss_n` is 1, and `s_sclk` and `s_mosi` are 0.
- R7: Readback lags by exactly one configured word. This holds across separate transfers and across consecutive words inside one page-mode transfer, because buffer write and read positions stay one word length apart.
- R8: A rising edge on `p_load` produces an `s_load` pulse that is high for exactly LOAD_SLOW cycles (8 by default) at speed code 0 or 1, and for exactly LOAD_FAST cycles (5 by default) at speed code 2 or 3.
- R9: While `p_cfg_n` is low and the primary select is high, the bits on `p_mosi` shift in MSB first on rising edges of `p_sclk`. On the rising edge of `p_cfg_n`, the last 8 bits are stored: bits 7:6 are the speed code and bits 5:0 are the word length minus one. At that point the read position is realigned to one word behind the write position.
- R10: After reset the speed code is 0, the word length is 8, the buffer holds zeros (so the first word read back is 0), and the downstream bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p_sclk | input | 1 | Host SPI clock |
| p_mosi | input | 1 | Host data into the bridge |
| p_ss_n | input | 1 | Host data-path select, active low |
| p_cfg_n | input | 1 | Host configuration select, active low |
| p_load | input | 1 | Host load strobe |
| p_miso | output | 1 | Delayed readback data to host |
| p_miso_oe | output | 1 | Drive enable for `p_miso` (low means high impedance) |
| s_sclk | output | 1 | Regenerated downstream clock |
| s_mosi | output | 1 | Downstream data out |
| s_ss_n | output | 1 | Downstream select, active low |
| s_load | output | 1 | Downstream load pulse |
| s_miso | input | 1 | Downstream reply data |

## Verification
The bound checker watches four things on every cycle:
- the secondary select follows the primary select (R1);
- the downstream clock falls when a bit arrives (R3);
- the downstream bus is idle whenever its select is high (R6);
- while idle and deselected, the write-minus-read distance in the buffer equals the word length, plus at most one bit that is still waiting for its falling-edge advance (R7).

Only the directed scenarios can show the rest. These are the exact low time at two speed settings, and which host edge moves `p_miso` (falling or rising). They also cover the one-word-late values across transfers and page boundaries, zero readback after reset, load pulse widths, and the decoding of configuration fields.

// File: rtl/iso_spi_bridge.sv
module iso_spi_bridge #(
  parameter int LOW_STEP  = 2,
  parameter int LOAD_FAST = 5,
  parameter int LOAD_SLOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p_sclk,
  input  logic p_mosi,
  input  logic p_ss_n,
  input  logic p_cfg_n,
  input  logic p_load,
  output logic p_miso,
  output logic p_miso_oe,
  output logic s_sclk,
  output logic s_mosi,
  output logic s_ss_n,
  output logic s_load,
  input  logic s_miso
);
  localparam int WL_W  = 6;
  localparam int DEPTH = 2 << WL_W;
  localparam int AW    = WL_W + 1;
  localparam int CNT_W = $clog2(1 + 3 * LOW_STEP) + 1;
  localparam int LD_W  = $clog2(LOAD_SLOW + 1);

  logic [4:0] sy0, sy1;
  logic sclk_q, cfg_q, load_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy0 <= 5'b01100; sy1 <= 5'b01100;
      sclk_q <= 1'b0; cfg_q <= 1'b1; load_q <= 1'b0;
    end else begin
      sy0 <= {p_load, p_cfg_n, p_ss_n, p_mosi, p_sclk};
      sy1 <= sy0;
      sclk_q <= sy1[0]; cfg_q <= sy1[3]; load_q <= sy1[4];
    end

  logic sclk_i, mosi_i, sel_act, cfg_act, rise, fall, cfg_done, load_rise;
  assign sclk_i    = sy1[0];
  assign mosi_i    = sy1[1];
  assign sel_act   = ~sy1[2];
  assign cfg_act   = ~sy1[3];
  assign rise      = sclk_i & ~sclk_q;
  assign fall      = ~sclk_i & sclk_q;
  assign cfg_done  = sy1[3] & ~cfg_q;
  assign load_rise = sy1[4] & ~load_q;

  logic [7:0]      cfg_sh;
  logic [1:0]      speed;
  logic [WL_W-1:0] wlen_m1;
  logic            fast;
  assign fast = speed[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_sh <= '0; speed <= 2'd0; wlen_m1 <= WL_W'(7);
    end else begin
      if (cfg_act && !sel_act && rise) cfg_sh <= {cfg_sh[6:0], mosi_i};
      if (cfg_done) begin
        speed   <= cfg_sh[7:6];
        wlen_m1 <= cfg_sh[5:0];
      end
    end

  logic fwd_vld, fwd_bit, rev_vld, rev_bit;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fwd_vld <= 1'b0; fwd_bit <= 1'b0;
    end else begin
      fwd_vld <= sel_act & rise;
      fwd_bit <= mosi_i;
    end

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wp, rp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mem <= '0; wp <= '0; rp <= AW'(DEPTH - 8);
    end else begin
      if (rev_vld) begin
        mem[wp] <= rev_bit;
        wp      <= wp + 1'b1;
      end
      if (cfg_done) rp <= wp - (AW'(cfg_sh[5:0]) + 1'b1);
      else if (sel_act && (fast ? rise : fall)) rp <= rp + 1'b1;
    end

  assign p_miso_oe = sel_act;
  assign p_miso    = sel_act & mem[rp];

  logic [CNT_W-1:0] low_cyc, cnt;
  logic busy, s_sclk_r, s_mosi_r, s_ss_r;
  assign low_cyc = CNT_W'(1 + LOW_STEP * (3 - int'(speed)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_sclk_r <= 1'b0; s_mosi_r <= 1'b0; s_ss_r <= 1'b1;
      busy <= 1'b0; cnt <= '0; rev_vld <= 1'b0; rev_bit <= 1'b0;
    end else begin
      rev_vld <= 1'b0;
      if (fwd_vld) begin
        s_mosi_r <= fwd_bit; s_sclk_r <= 1'b0; s_ss_r <= 1'b0;
        cnt <= low_cyc; busy <= 1'b1;
      end else if (busy) begin
        if (cnt == CNT_W'(1)) begin
          s_sclk_r <= 1'b1; busy <= 1'b0;
          rev_vld <= 1'b1; rev_bit <= s_miso;
        end else cnt <= cnt - 1'b1;
      end else if (sel_act) s_ss_r <= 1'b0;
      else begin
        s_ss_r <= 1'b1; s_sclk_r <= 1'b0; s_mosi_r <= 1'b0;
      end
    end

  assign s_sclk = s_sclk_r;
  assign s_mosi = s_mosi_r;
  assign s_ss_n = s_ss_r;

  logic [LD_W-1:0] ld_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ld_cnt <= '0;
    else if (load_rise) ld_cnt <= fast ? LD_W'(LOAD_FAST) : LD_W'(LOAD_SLOW);
    else if (ld_cnt != '0) ld_cnt <= ld_cnt - 1'b1;
  assign s_load = (ld_cnt != '0);
endmodule

module iso_spi_bridge_chk #(
  parameter int AW   = 7,
  parameter int WL_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_act,
  input logic            fwd_vld,
  input logic            busy,
  input logic            rev_vld,
  input logic            s_sclk,
  input logic            s_mosi,
  input logic            s_ss_n,
  input logic [AW-1:0]   wp,
  input logic [AW-1:0]   rp,
  input logic [WL_W-1:0] wlen_m1
);
  logic [AW-1:0] gap, wl;
  assign gap = wp - rp;
  assign wl  = AW'(wlen_m1) + 1'b1;

  AST_SS2_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act |=> !s_ss_n); // R1
  AST_BIT_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |=> !s_sclk); // R3
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    s_ss_n |-> (!s_sclk && !s_mosi)); // R6
  AST_PTR_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_act && !busy && !fwd_vld && !rev_vld) |-> (gap == wl || gap == wl + 1'b1)); // R7
endmodule

bind iso_spi_bridge iso_spi_bridge_chk #(.AW(AW), .WL_W(WL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .fwd_vld(fwd_vld), .busy(busy),
  .rev_vld(rev_vld), .s_sclk(s_sclk), .s_mosi(s_mosi), .s_ss_n(s_ss_n),
  .wp(wp), .rp(rp), .wlen_m1(wlen_m1));

// File: tb/iso_spi_bridge_tb.sv
module iso_spi_bridge_tb;
  localparam int HALF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_ss_n = 1'b1, p_cfg_n = 1'b1, p_load = 1'b0;
  logic p_miso, p_miso_oe, s_sclk, s_mosi, s_ss_n, s_load, s_miso;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iso_spi_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .p_sclk(p_sclk), .p_mosi(p_mosi), .p_ss_n(p_ss_n),
    .p_cfg_n(p_cfg_n), .p_load(p_load), .p_miso(p_miso), .p_miso_oe(p_miso_oe),
    .s_sclk(s_sclk), .s_mosi(s_mosi), .s_ss_n(s_ss_n), .s_load(s_load), .s_miso(s_miso));

  logic [63:0] slv_tx = '0, slv_rx = '0;
  int slv_cnt = 0;
  always @(posedge s_sclk or posedge s_ss_n)
    if (s_ss_n) slv_cnt <= 0;
    else begin
      slv_cnt <= slv_cnt + 1;
      slv_rx  <= {slv_rx[62:0], s_mosi};
    end
  assign s_miso = slv_tx[63 - (slv_cnt % 64)];

  int run = 0, last_low = 0;
  always @(negedge clk)
    if (s_ss_n) run <= 0;
    else if (!s_sclk) run <= run + 1;
    else if (run != 0) begin last_low <= run; run <= 0; end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [63:0] hw, output logic [63:0] rd,
                      output logic [63:0] mid, output logic ss2, output logic oe);
    rd = '0; mid = '0;
    p_ss_n = 1'b0;
    cyc(HALF);
    ss2 = s_ss_n; oe = p_miso_oe;
    for (int k = 0; k < n; k++) begin
      p_mosi = hw[n-1-k];
      cyc(HALF);
      rd = {rd[62:0], p_miso};
      p_sclk = 1'b1;
      cyc(HALF);
      mid = {mid[62:0], p_miso};
      p_sclk = 1'b0;
    end
    cyc(HALF);
    p_ss_n = 1'b1;
    cyc(4 * HALF);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    p_cfg_n = 1'b0;
    cyc(HALF);
    for (int k = 7; k >= 0; k--) begin
      p_mosi = v[k];
      cyc(HALF); p_sclk = 1'b1;
      cyc(HALF); p_sclk = 1'b0;
    end
    cyc(HALF);
    p_cfg_n = 1'b1;
    cyc(4 * HALF);
  endtask

  task automatic load_width(output int w);
    w = 0;
    p_load = 1'b1;
    cyc(3);
    p_load = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (s_load) w++;
      cyc(1);
    end
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R10 oe idle", p_miso_oe, 0);
    chk("R10 s_ss_n idle", s_ss_n, 1);
    chk("R10 s_sclk idle", s_sclk, 0);
    chk("R10 s_load idle", s_load, 0);
  endtask

  task automatic t_normal_speed;
    logic [63:0] rd, mid; logic ss2, oe;
    slv_tx = 64'hC3 << 56;
    xfer(8, 64'hA5, rd, mid, ss2, oe);
    chk("R10 first readback zero", rd & 64'hFF, 0);
    chk("R1 s_ss_n low after select", ss2, 0);
    chk("R1 oe high after select", oe, 1);
    chk("R2 downstream got host word", slv_rx & 64'hFF, 64'hA5);
    chk("R3 low time speed0", 64'(last_low), 7);
    chk("R6 oe off after deselect", p_miso_oe, 0);
    chk("R6 s_ss_n high", s_ss_n, 1);
    chk("R6 s_sclk/s_mosi low", {s_sclk, s_mosi}, 0);
    slv_tx = 64'h5A << 56;
    xfer(8, 64'h3C, rd, mid, ss2, oe);
    chk("R7 one word late", rd & 64'hFF, 64'hC3);
    chk("R1 MSB of previous word first", (rd >> 7) & 1, 1);
    chk("R4 no advance while sclk high", mid & 64'hFF, rd & 64'hFF);
    chk("R2 second word", slv_rx & 64'hFF, 64'h3C);
  endtask

  task automatic t_fast_page;
    logic [63:0] rd, mid; logic ss2, oe;
    cfg_write(8'hCB);
    slv_tx = 64'h9E1 << 52;
    xfer(12, 64'h123, rd, mid, ss2, oe);
    chk("R9 word length 12 forwarded", slv_rx & 64'hFFF, 64'h123);
    chk("R3 low time speed3", 64'(last_low), 1);
    slv_tx = 64'hB4C_2D7 << 40;
    xfer(24, 64'hF0E_1D2, rd, mid, ss2, oe);
    chk("R7 page word0 is previous transfer", (rd >> 12) & 64'hFFF, 64'h9E1);
    chk("R7 page word1 is first page word", rd & 64'hFFF, 64'hB4C);
    chk("R2 page host bits", slv_rx & 64'hFF_FFFF, 64'hF0E_1D2);
    chk("R5 advance on rising edge", mid >> 1, rd & 64'h7F_FFFF);
    slv_tx = '0;
    xfer(12, 64'h0, rd, mid, ss2, oe);
    chk("R7 page second word returned", rd & 64'hFFF, 64'h2D7);
  endtask

  task automatic t_load;
    int w;
    load_width(w);
    chk("R8 load width fast", 64'(w), 5);
    cfg_write(8'h07);
    load_width(w);
    chk("R8 load width slow", 64'(w), 8);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_normal_speed();
    t_fast_page();
    t_load();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule